// File: doc/BRIEF.md
# Compressed Branch Trace Encoder

This block turns a stream of CPU trace events into short messages on a 4-bit trace port. An event is either a taken branch, identified by its source address, or a memory access. A memory access is traced only when its address falls inside one of two programmable address windows and its direction (read or write) is enabled for that window. Branch events are always traced.

Each traced address is compared with the last address sent of the same class. Branch sources are compared with the previous branch source, and window accesses with the previous window access. Only the low-order part that differs is sent: 4, 8, 16 or the full 32 bits. A message starts with one header nibble marked by the active-low sync line. Its payload nibbles follow, least significant first, one per clock. The port runs on the block clock: a nibble is valid in every cycle where `trc_en` is high.

A small queue decouples event arrival from the port. When the queue is full, one of two policies applies. In realtime mode a new event is discarded and the CPU never waits. In stall mode `cpu_stall` is raised, and the CPU holds its event until the queue has room.

Top module: `trc_branch_enc`

## Requirements
- R1: After reset, `trc_en` is 0, `trc_sync_n` is 1, `trc_data` is 0 and `cpu_stall` is 0. Both previous-address registers are zero, so the first address of each class is compared with zero. While `trc_en` is 0, `trc_sync_n` stays 1 and `trc_data` stays 0.
- R2: Every message begins with a header nibble sent with `trc_en`=1 and `trc_sync_n`=0. In the header, bit 3 is the class (0 branch, 1 window access), bit 2 is 1 only for a window write, and bits 1:0 are the length code. The payload nibbles follow on consecutive cycles with `trc_en`=1 and `trc_sync_n`=1, least significant nibble first.
- R3: The length code depends on how much of the new address matches the reference address. If bits 31:4 match, the code is 0 and 1 nibble (bits 3:0) is sent. Otherwise, if bits 31:8 match, the code is 1 and 2 nibbles are sent. Otherwise, if bits 31:16 match, the code is 2 and 4 nibbles are sent. Otherwise the code is 3 and all 8 nibbles are sent.
- R4: Branch addresses use the last sent branch address as their reference. Window addresses use the last sent window address as theirs. A message of one class never changes the reference of the other class.
- R5: A memory access is traced only if, for channel A or channel B, lo ≤ address ≤ hi (both bounds inclusive) and the channel's select field allows the access. Select bit 0 enables reads and bit 1 enables writes. An access that is not traced produces no message and does not change the window reference.
- R6: With `rt_mode`=1, an event presented while the queue holds DEPTH entries is discarded. `cpu_stall` never rises, and a discarded event does not change any reference address.
- R7: With `rt_mode`=0, `cpu_stall` is high exactly while the queue is full. An event presented while `cpu_stall` is high is not taken, and it is accepted on the first edge where `cpu_stall` is low. No event is lost.
- R8: Messages leave in event arrival order. The next header follows the last payload nibble of the previous message with no idle cycle when the queue is not empty.
- R9: Branch events are traced regardless of the window settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the trace port clock |
| rst | input | 1 | Synchronous active-high reset |
| rt_mode | input | 1 | 1: discard on full queue; 0: stall the CPU |
| ev_valid | input | 1 | Event present this cycle |
| ev_is_mem | input | 1 | 0: branch event, 1: memory access |
| ev_write | input | 1 | Memory access direction, 1 = write |
| ev_addr | input | 32 | Branch source or memory access address |
| win_a_lo | input | 32 | Channel A lower bound, inclusive |
| win_a_hi | input | 32 | Channel A upper bound, inclusive |
| win_a_sel | input | 2 | Channel A cycle select (bit 0 read, bit 1 write) |
| win_b_lo | input | 32 | Channel B lower bound, inclusive |
| win_b_hi | input | 32 | Channel B upper bound, inclusive |
| win_b_sel | input | 2 | Channel B cycle select (bit 0 read, bit 1 write) |
| cpu_stall | output | 1 | Hold request to the CPU (stall mode only) |
| trc_en | output | 1 | Trace nibble valid this cycle |
| trc_sync_n | output | 1 | Low on the header nibble of a message |
| trc_data | output | 4 | Trace nibble |

## Verification
The hardest state to reach is a full queue while the serializer is still busy with a long message. Reaching it requires consecutive events whose addresses differ in their upper 16 bits, so that each message runs nine cycles and the queue cannot drain. The bench issues four such branch events on back-to-back cycles, once in each overflow mode. In realtime mode it then sends an address close to the discarded one, which shows that the discarded event left the reference untouched. In stall mode the driver holds each event while `cpu_stall` is high, and the bench confirms that the stall was seen and that all four messages arrive in order.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int TRC_AW  = 32;
  localparam int TRC_NIB = TRC_AW / 4;

  typedef struct packed {
    logic              is_mem;
    logic              wr;
    logic [TRC_AW-1:0] addr;
  } trc_ev_t;

  localparam int TRC_EV_W = $bits(trc_ev_t);

  // length code from the number of matching upper bits
  function automatic logic [1:0] len_code(input logic [TRC_AW-1:0] cur,
                                          input logic [TRC_AW-1:0] ref_a);
    if (cur[TRC_AW-1:4] == ref_a[TRC_AW-1:4])       return 2'd0;
    else if (cur[TRC_AW-1:8] == ref_a[TRC_AW-1:8])  return 2'd1;
    else if (cur[TRC_AW-1:16] == ref_a[TRC_AW-1:16]) return 2'd2;
    else                                             return 2'd3;
  endfunction

  function automatic logic [3:0] nib_count(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd1;
      2'd1:    return 4'd2;
      2'd2:    return 4'd4;
      default: return 4'(TRC_NIB);
    endcase
  endfunction
endpackage

// File: rtl/trc_win_filter.sv
module trc_win_filter
  import trc_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic [NCH-1:0][TRC_AW-1:0] lo,
  input  logic [NCH-1:0][TRC_AW-1:0] hi,
  input  logic [NCH-1:0][1:0]        sel,
  input  logic [TRC_AW-1:0]          addr,
  input  logic                       wr,
  output logic                       hit
);
  logic [NCH-1:0] ch_hit;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic in_range;
    logic dir_ok;
    assign in_range = (addr >= lo[c]) && (addr <= hi[c]);
    assign dir_ok   = wr ? sel[c][1] : sel[c][0];
    assign ch_hit[c] = in_range && dir_ok;
  end

  assign hit = |ch_hit;
endmodule

// File: rtl/trc_fifo.sv
module trc_fifo #(
  parameter int W     = 34,
  parameter int DEPTH = 2,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] occ
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = mem[rd_ptr];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign occ   = cnt;
endmodule

// File: rtl/trc_serializer.sv
module trc_serializer
  import trc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  trc_ev_t    head,
  input  logic       empty,
  output logic       pop,
  output logic       trc_en,
  output logic       trc_sync_n,
  output logic [3:0] trc_data
);
  logic [TRC_AW-1:0] prev_br, prev_win, ref_addr, sh;
  logic [3:0]        left;
  logic [1:0]        code;

  always_comb begin
    ref_addr = head.is_mem ? prev_win : prev_br;
    code     = len_code(head.addr, ref_addr);
    pop      = (left == '0) && !empty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_br    <= '0;
      prev_win   <= '0;
      sh         <= '0;
      left       <= '0;
      trc_en     <= 1'b0;
      trc_sync_n <= 1'b1;
      trc_data   <= '0;
    end else if (left != '0) begin
      trc_en     <= 1'b1;
      trc_sync_n <= 1'b1;
      trc_data   <= sh[3:0];
      sh         <= sh >> 4;
      left       <= left - 1'b1;
    end else if (!empty) begin
      trc_en     <= 1'b1;
      trc_sync_n <= 1'b0;
      trc_data   <= {head.is_mem, head.is_mem & head.wr, code};
      sh         <= head.addr;
      left       <= nib_count(code);
      if (head.is_mem) prev_win <= head.addr;
      else             prev_br  <= head.addr;
    end else begin
      trc_en     <= 1'b0;
      trc_sync_n <= 1'b1;
      trc_data   <= '0;
    end
  end
endmodule

// File: rtl/trc_branch_enc.sv
module trc_branch_enc
  import trc_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rt_mode,
  input  logic              ev_valid,
  input  logic              ev_is_mem,
  input  logic              ev_write,
  input  logic [TRC_AW-1:0] ev_addr,
  input  logic [TRC_AW-1:0] win_a_lo,
  input  logic [TRC_AW-1:0] win_a_hi,
  input  logic [1:0]        win_a_sel,
  input  logic [TRC_AW-1:0] win_b_lo,
  input  logic [TRC_AW-1:0] win_b_hi,
  input  logic [1:0]        win_b_sel,
  output logic              cpu_stall,
  output logic              trc_en,
  output logic              trc_sync_n,
  output logic [3:0]        trc_data
);
  logic [1:0][TRC_AW-1:0] w_lo, w_hi;
  logic [1:0][1:0]        w_sel;
  logic                   win_hit, take, push, pop, q_empty, q_full;
  logic [CW-1:0]          fifo_occ;
  trc_ev_t                ev_in, ev_head;

  assign w_lo  = {win_b_lo, win_a_lo};
  assign w_hi  = {win_b_hi, win_a_hi};
  assign w_sel = {win_b_sel, win_a_sel};

  trc_win_filter #(.NCH(2)) filt_i (
    .lo(w_lo), .hi(w_hi), .sel(w_sel),
    .addr(ev_addr), .wr(ev_write), .hit(win_hit)
  );

  assign cpu_stall = !rt_mode && q_full;
  assign take      = ev_valid && !cpu_stall && (!ev_is_mem || win_hit);
  assign push      = take && !q_full;
  assign ev_in     = '{is_mem: ev_is_mem, wr: ev_write, addr: ev_addr};

  trc_fifo #(.W(TRC_EV_W), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst(rst), .push(push), .din(ev_in), .pop(pop),
    .dout(ev_head), .empty(q_empty), .full(q_full), .occ(fifo_occ)
  );

  trc_serializer ser_i (
    .clk(clk), .rst(rst), .head(ev_head), .empty(q_empty), .pop(pop),
    .trc_en(trc_en), .trc_sync_n(trc_sync_n), .trc_data(trc_data)
  );
endmodule

// File: rtl/trc_branch_enc_chk.sv
module trc_branch_enc_chk #(
  parameter int DEPTH = 2,
  parameter int CW    = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          ev_valid,
  input logic          cpu_stall,
  input logic          trc_en,
  input logic          trc_sync_n,
  input logic [3:0]    trc_data,
  input logic [CW-1:0] fifo_occ
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    fifo_occ <= CW'(DEPTH)); // R6

  AST_STALL_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    cpu_stall |-> (fifo_occ == CW'(DEPTH))); // R7

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (cpu_stall && ev_valid) |=> (fifo_occ <= $past(fifo_occ))); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !trc_en |-> (trc_sync_n && trc_data == 4'h0)); // R1

  AST_HDR_PAYLOAD: assert property (@(posedge clk) disable iff (rst)
    (trc_en && !trc_sync_n) |=> (trc_en && trc_sync_n)); // R2
endmodule

bind trc_branch_enc trc_branch_enc_chk chk_i (
  .clk(clk), .rst(rst), .ev_valid(ev_valid), .cpu_stall(cpu_stall),
  .trc_en(trc_en), .trc_sync_n(trc_sync_n), .trc_data(trc_data),
  .fifo_occ(fifo_occ)
);

// File: tb/trc_branch_enc_tb.sv
module trc_branch_enc_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rt_mode = 1'b1;
  logic        ev_valid = 1'b0, ev_is_mem = 1'b0, ev_write = 1'b0;
  logic [31:0] ev_addr = '0;
  logic        cpu_stall, trc_en, trc_sync_n;
  logic [3:0]  trc_data;

  int total = 0, bad = 0, cycles = 0, stall_seen = 0, msg_n = 0, pos = 0;
  logic [3:0]  msg_hdr [64];
  logic [31:0] msg_val [64];
  int          msg_len [64];

  always #4 clk = ~clk;  // 125 MHz

  // windows: A = 0x1000_0000..0x1000_FFFF reads only; B = 0x2000_0000..0x2000_00FF both
  trc_branch_enc dut_i (
    .clk(clk), .rst(rst), .rt_mode(rt_mode),
    .ev_valid(ev_valid), .ev_is_mem(ev_is_mem), .ev_write(ev_write), .ev_addr(ev_addr),
    .win_a_lo(32'h1000_0000), .win_a_hi(32'h1000_FFFF), .win_a_sel(2'b01),
    .win_b_lo(32'h2000_0000), .win_b_hi(32'h2000_00FF), .win_b_sel(2'b11),
    .cpu_stall(cpu_stall), .trc_en(trc_en), .trc_sync_n(trc_sync_n), .trc_data(trc_data)
  );

  // message capture
  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (cpu_stall) stall_seen <= stall_seen + 1;
    if (!rst && trc_en) begin
      if (!trc_sync_n) begin
        if (msg_n < 64) begin
          msg_hdr[msg_n] = trc_data;
          msg_val[msg_n] = '0;
          msg_len[msg_n] = 0;
        end
        msg_n = msg_n + 1;
        pos = 0;
      end else if (msg_n > 0 && msg_n <= 64) begin
        if (pos < 8) msg_val[msg_n-1] = msg_val[msg_n-1] | (32'(trc_data) << (4 * pos));
        msg_len[msg_n-1] = msg_len[msg_n-1] + 1;
        pos = pos + 1;
      end
    end
  end

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) if (cycles > 100000) begin
    total++; bad++;
    $display("FAIL watchdog: actual=%0d cycles expected<100000", cycles);
    finish_up();
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] masked(input logic [31:0] a, input int len);
    return (len >= 8) ? a : (a & ((32'h1 << (4 * len)) - 1));
  endfunction

  function automatic int len_of(input logic [3:0] hdr);
    case (hdr[1:0]) 2'd0: return 1; 2'd1: return 2; 2'd2: return 4; default: return 8; endcase
  endfunction

  // check message idx against expected header and address
  task automatic chk_msg(input int idx, input logic [3:0] hdr, input logic [31:0] a, input string tag);
    chk({tag, " hdr"}, 32'(msg_hdr[idx]), 32'(hdr));
    chk({tag, " len"}, 32'(msg_len[idx]), 32'(len_of(hdr)));
    chk({tag, " val"}, msg_val[idx], masked(a, len_of(hdr)));
  endtask

  task automatic drive(input logic m, input logic w, input logic [31:0] a);
    ev_valid = 1'b1; ev_is_mem = m; ev_write = w; ev_addr = a;
  endtask

  task automatic send_hold(input logic [31:0] a);
    @(negedge clk); drive(1'b0, 1'b0, a);
    while (cpu_stall) @(negedge clk);
    @(negedge clk); ev_valid = 1'b0;
  endtask

  // {is_mem, write, addr, header, traced}
  localparam logic [38:0] VEC [12] = '{
    {1'b0, 1'b0, 32'h0000_0004, 4'h0, 1'b1},
    {1'b0, 1'b0, 32'h0000_0038, 4'h1, 1'b1},
    {1'b0, 1'b0, 32'h0012_3456, 4'h3, 1'b1},
    {1'b0, 1'b0, 32'h0012_9000, 4'h2, 1'b1},
    {1'b1, 1'b0, 32'h1000_0010, 4'hB, 1'b1},
    {1'b1, 1'b0, 32'h1000_0014, 4'h8, 1'b1},
    {1'b1, 1'b1, 32'h1000_0020, 4'h0, 1'b0},
    {1'b1, 1'b0, 32'h1000_0018, 4'h8, 1'b1},
    {1'b1, 1'b1, 32'h2000_0040, 4'hF, 1'b1},
    {1'b1, 1'b0, 32'h2000_0100, 4'h0, 1'b0},
    {1'b0, 1'b0, 32'h0012_9008, 4'h0, 1'b1},
    {1'b1, 1'b0, 32'h2000_0047, 4'h8, 1'b1}
  };

  initial begin
    int base;
    int st0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 trc_en", 32'(trc_en), 32'd0);
    chk("R1 sync_n", 32'(trc_sync_n), 32'd1);
    chk("R1 data", 32'(trc_data), 32'd0);
    chk("R1 stall", 32'(cpu_stall), 32'd0);

    // vector table: R2 header, R3 length, R4 separate references, R5 windows, R9 branches
    for (int i = 0; i < 12; i++) begin
      base = msg_n;
      @(negedge clk); drive(VEC[i][38], VEC[i][37], VEC[i][36:5]);
      @(negedge clk); ev_valid = 1'b0;
      repeat (20) @(negedge clk);
      if (VEC[i][0]) begin
        chk("R2 msg count", 32'(msg_n - base), 32'd1);
        chk_msg(base, VEC[i][4:1], VEC[i][36:5], VEC[i][38] ? "R5" : "R9");
      end else begin
        chk("R5 untraced access", 32'(msg_n - base), 32'd0);
      end
    end

    // R6 realtime overflow: four long messages back to back, fourth discarded
    rt_mode = 1'b1;
    st0 = stall_seen;
    base = msg_n;
    @(negedge clk); drive(1'b0, 1'b0, 32'h4000_0000);
    @(negedge clk); drive(1'b0, 1'b0, 32'h5000_0000);
    @(negedge clk); drive(1'b0, 1'b0, 32'h7000_0000);
    @(negedge clk); drive(1'b0, 1'b0, 32'h7100_0000);
    @(negedge clk); ev_valid = 1'b0;
    repeat (40) @(negedge clk);
    chk("R6 kept count", 32'(msg_n - base), 32'd3);
    chk_msg(base,     4'h3, 32'h4000_0000, "R8");
    chk_msg(base + 1, 4'h3, 32'h5000_0000, "R8");
    chk_msg(base + 2, 4'h3, 32'h7000_0000, "R8");
    chk("R6 no stall", 32'(stall_seen - st0), 32'd0);
    // discarded event must not have moved the branch reference
    base = msg_n;
    @(negedge clk); drive(1'b0, 1'b0, 32'h7100_0001);
    @(negedge clk); ev_valid = 1'b0;
    repeat (20) @(negedge clk);
    chk_msg(base, 4'h3, 32'h7100_0001, "R6");

    // R7 stall mode: same burst, nothing lost
    rt_mode = 1'b0;
    st0 = stall_seen;
    base = msg_n;
    send_hold(32'h8000_0000);
    send_hold(32'h9000_0000);
    send_hold(32'hA000_0000);
    send_hold(32'hB000_0000);
    repeat (50) @(negedge clk);
    chk("R7 delivered", 32'(msg_n - base), 32'd4);
    chk("R7 stall seen", 32'(stall_seen - st0 > 0), 32'd1);
    chk_msg(base,     4'h3, 32'h8000_0000, "R7");
    chk_msg(base + 3, 4'h3, 32'hB000_0000, "R7");
    chk("R7 stall released", 32'(cpu_stall), 32'd0);

    // R4: branch reference untouched by window traffic (0x0012_9008 gave code 0 above)
    base = msg_n;
    @(negedge clk); drive(1'b0, 1'b0, 32'hB000_0005);
    @(negedge clk); ev_valid = 1'b0;
    repeat (20) @(negedge clk);
    chk_msg(base, 4'h0, 32'hB000_0005, "R4");
    finish_up();
  end
endmodule